// File: doc/BRIEF.md
# Bidirectional Port Access Decoder

This block decodes the control pins of one side of a dual-FIFO bidirectional port. A single shared data bus carries words in both directions. The block takes the following inputs:

- an active-low chip select;
- a direction select;
- a clock enable;
- a mailbox select;
- the room-available status of the outgoing FIFO;
- the data-available status of the incoming FIFO.

From these it produces four things. A push strobe writes into the outgoing FIFO. A pop strobe reads from the incoming FIFO. A pair of mailbox strobes serves accesses that target the mailbox path instead of the FIFOs. A per-bit output enable drives the shared bus.

Bus direction is decoded combinationally from chip select and direction select alone. It does not depend on the clock enable. This means the pads turn around as soon as the select pins settle. Operations are qualified at the rising clock edge and issued as one-cycle strobes.

A parameter inverts the meaning of the direction select. The same block can then serve the second port, where a low direction level means "write". A second parameter chooses between registered strobes and combinational strobes. Two instances, one per port, are fully independent.

Top module: `bpd_port_decode`

## Requirements
- R1: `bus_oe` is all ones exactly when `sel_n` is 0 and `dir` is at the read level, and all zeros otherwise. It follows `sel_n` and `dir` without waiting for a clock edge and ignores `en`, `mbx_sel` and both status inputs.
- R2: A rising edge with `sel_n`=0, `dir` at the write level, `en`=1, `mbx_sel`=0 and `room_ok`=1 makes `push_stb` high for the cycle after that edge (registered variant, the default).
- R3: A rising edge with `sel_n`=0, `dir` at the read level, `en`=1, `mbx_sel`=0 and `data_ok`=1 makes `pop_stb` high for the cycle after that edge.
- R4: When `en` is 0 at a rising edge, no strobe is high in the following cycle, whatever `sel_n` and `dir` do.
- R5: When `mbx_sel` is 1 at a qualifying edge, `push_stb` and `pop_stb` stay low. Instead, `mbx_wr_stb` rises at the write level or `mbx_rd_stb` rises at the read level, regardless of `room_ok` and `data_ok`.
- R6: `room_ok`=0 blocks `push_stb`, and `data_ok`=0 blocks `pop_stb`.
- R7: The write level is `dir`=1 when `SECOND_PORT`=0 and `dir`=0 when `SECOND_PORT`=1. The read level is always the opposite value.
- R8: At most one of the four strobes is high in any cycle.
- R9: While `rst_n` is 0, all strobes are low.
- R10: Each qualifying edge produces exactly one strobe cycle. N back-to-back qualifying edges give N consecutive strobe cycles, and the strobe drops in the cycle after the first non-qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the strobe stage |
| sel_n | input | 1 | Active-low chip select |
| dir | input | 1 | Direction select; polarity set by SECOND_PORT |
| en | input | 1 | Clock enable qualifying any access |
| mbx_sel | input | 1 | Routes the access to the mailbox path |
| room_ok | input | 1 | Outgoing FIFO can accept a word |
| data_ok | input | 1 | Incoming FIFO holds a word for reading |
| bus_oe | output | BUS_W | Output enable for each bit of the shared data bus |
| push_stb | output | 1 | Write strobe into the outgoing FIFO |
| pop_stb | output | 1 | Read strobe from the incoming FIFO |
| mbx_wr_stb | output | 1 | Mailbox write strobe |
| mbx_rd_stb | output | 1 | Mailbox read strobe |

## Verification
The clocked assertions assume that all control and status inputs are known and stable around each rising edge. They also assume that the status flags report the FIFO state of the same cycle. The bench keeps within this by changing every input only on the falling edge. It sweeps all 64 combinations of the six control and status inputs through a first-port and a second-port instance side by side. The output enable is sampled shortly after the falling-edge change, before any clock edge, so that its clock-free decode is observed on its own.

// File: rtl/bpd_pkg.sv
`timescale 1ns/1ps
package bpd_pkg;

   // One bit per access kind; a legal result has at most one bit set.
   typedef struct packed {
      logic push;
      logic pop;
      logic mbx_wr;
      logic mbx_rd;
   } bpd_strobe_t;

   localparam bpd_strobe_t BPD_IDLE = '{push: 1'b0, pop: 1'b0, mbx_wr: 1'b0, mbx_rd: 1'b0};

   function automatic logic bpd_wr_level(input int second_port);
      return (second_port == 0) ? 1'b1 : 1'b0;
   endfunction

endpackage

// File: rtl/bpd_dir_decode.sv
`timescale 1ns/1ps
module bpd_dir_decode
   import bpd_pkg::*;
#(
   parameter int SECOND_PORT = 0,
   parameter int BUS_W       = 36
) (
   input  logic             sel_n,
   input  logic             dir,
   output logic             wr_dir,
   output logic             rd_dir,
   output logic [BUS_W-1:0] oe
);
   localparam logic WR_LVL = bpd_wr_level(SECOND_PORT);

   logic drive;

   always_comb begin
      wr_dir = (dir == WR_LVL);
      rd_dir = (dir != WR_LVL);
      drive  = ~sel_n & rd_dir;
   end

   // One enable per pad, so the layout can place each driver by its bit.
   for (genvar b = 0; b < BUS_W; b++) begin : g_oe
      assign oe[b] = drive;
   end

   always_comb begin
      if (!$isunknown({sel_n, dir})) begin
         AST_DIR_EXCL: assert (wr_dir ^ rd_dir); // R7
      end
   end
endmodule

// File: rtl/bpd_access_qualify.sv
`timescale 1ns/1ps
module bpd_access_qualify
   import bpd_pkg::*;
(
   input  logic        sel_n,
   input  logic        en,
   input  logic        mbx_sel,
   input  logic        wr_dir,
   input  logic        rd_dir,
   input  logic        room_ok,
   input  logic        data_ok,
   output bpd_strobe_t req
);
   logic port_live;
   logic fifo_path;
   logic mbx_path;

   always_comb begin
      port_live  = ~sel_n & en;
      fifo_path  = port_live & ~mbx_sel;
      mbx_path   = port_live & mbx_sel;
      req        = BPD_IDLE;
      req.push   = fifo_path & wr_dir & room_ok;
      req.pop    = fifo_path & rd_dir & data_ok;
      req.mbx_wr = mbx_path & wr_dir;
      req.mbx_rd = mbx_path & rd_dir;
   end

   always_comb begin
      if (!$isunknown({sel_n, en, mbx_sel, wr_dir, rd_dir, room_ok, data_ok})) begin
         AST_REQ_ONEHOT: assert ($onehot0(req)); // R8
      end
   end
endmodule

// File: rtl/bpd_strobe_stage.sv
`timescale 1ns/1ps
module bpd_strobe_stage
   import bpd_pkg::*;
#(
   parameter int STROBE_REG = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  bpd_strobe_t req,
   output bpd_strobe_t stb
);
   if (STROBE_REG != 0) begin : g_reg
      bpd_strobe_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= BPD_IDLE;
         else        q <= req;
      end
      assign stb = q;
   end else begin : g_comb
      assign stb = rst_n ? req : BPD_IDLE;
   end
endmodule

// File: rtl/bpd_port_decode.sv
`timescale 1ns/1ps
module bpd_port_decode
   import bpd_pkg::*;
#(
   parameter int SECOND_PORT = 0,
   parameter int BUS_W       = 36,
   parameter int STROBE_REG  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             dir,
   input  logic             en,
   input  logic             mbx_sel,
   input  logic             room_ok,
   input  logic             data_ok,
   output logic [BUS_W-1:0] bus_oe,
   output logic             push_stb,
   output logic             pop_stb,
   output logic             mbx_wr_stb,
   output logic             mbx_rd_stb
);
   if (BUS_W < 1) begin : g_bad_width
      $error("bpd_port_decode: BUS_W must be at least 1");
   end
   if (SECOND_PORT != 0 && SECOND_PORT != 1) begin : g_bad_port
      $error("bpd_port_decode: SECOND_PORT must be 0 or 1");
   end
   if (STROBE_REG != 0 && STROBE_REG != 1) begin : g_bad_reg
      $error("bpd_port_decode: STROBE_REG must be 0 or 1");
   end

   logic        wr_dir;
   logic        rd_dir;
   bpd_strobe_t req;
   bpd_strobe_t stb;

   bpd_dir_decode #(
      .SECOND_PORT (SECOND_PORT),
      .BUS_W       (BUS_W)
   ) u_dir (
      .sel_n  (sel_n),
      .dir    (dir),
      .wr_dir (wr_dir),
      .rd_dir (rd_dir),
      .oe     (bus_oe)
   );

   bpd_access_qualify u_qual (
      .sel_n   (sel_n),
      .en      (en),
      .mbx_sel (mbx_sel),
      .wr_dir  (wr_dir),
      .rd_dir  (rd_dir),
      .room_ok (room_ok),
      .data_ok (data_ok),
      .req     (req)
   );

   bpd_strobe_stage #(
      .STROBE_REG (STROBE_REG)
   ) u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .stb   (stb)
   );

   assign push_stb   = stb.push;
   assign pop_stb    = stb.pop;
   assign mbx_wr_stb = stb.mbx_wr;
   assign mbx_rd_stb = stb.mbx_rd;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_stb, pop_stb, mbx_wr_stb, mbx_rd_stb})); // R8

   AST_OE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (|bus_oe) |-> !(req.push || req.mbx_wr)); // R1

   if (STROBE_REG != 0) begin : g_reg_chk
      AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> !(push_stb || pop_stb || mbx_wr_stb || mbx_rd_stb)); // R4
      AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
         !room_ok |=> !push_stb); // R6
      AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
         !data_ok |=> !pop_stb); // R6
      AST_MBX_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
         mbx_sel |=> !(push_stb || pop_stb)); // R5
      AST_PUSH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
         (req.push && $past(rst_n)) |=> push_stb); // R2
   end else begin : g_comb_chk
      AST_EN_GATE_C: assert property (@(posedge clk) disable iff (!rst_n)
         !en |-> !(push_stb || pop_stb || mbx_wr_stb || mbx_rd_stb)); // R4
      AST_MBX_BLOCK_C: assert property (@(posedge clk) disable iff (!rst_n)
         mbx_sel |-> !(push_stb || pop_stb)); // R5
   end
endmodule

// File: tb/bpd_port_decode_tb.sv
`timescale 1ns/1ps
module bpd_port_decode_tb_top;
   localparam int BUS_W = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, dir = 1'b0, en = 1'b0, mbx_sel = 1'b0, room_ok = 1'b0, data_ok = 1'b0;

   logic [BUS_W-1:0] a_oe, b_oe;
   logic a_push, a_pop, a_mwr, a_mrd;
   logic b_push, b_pop, b_mwr, b_mrd;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bpd_port_decode #(.SECOND_PORT(0), .BUS_W(BUS_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir(dir), .en(en),
      .mbx_sel(mbx_sel), .room_ok(room_ok), .data_ok(data_ok),
      .bus_oe(a_oe), .push_stb(a_push), .pop_stb(a_pop),
      .mbx_wr_stb(a_mwr), .mbx_rd_stb(a_mrd));

   bpd_port_decode #(.SECOND_PORT(1), .BUS_W(BUS_W)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir(dir), .en(en),
      .mbx_sel(mbx_sel), .room_ok(room_ok), .data_ok(data_ok),
      .bus_oe(b_oe), .push_stb(b_push), .pop_stb(b_pop),
      .mbx_wr_stb(b_mwr), .mbx_rd_stb(b_mrd));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected strobes as {push, pop, mbx_wr, mbx_rd}, from R2..R7
   function automatic logic [3:0] exp_stb(input int second);
      logic wr_lvl;
      logic live;
      wr_lvl = (second == 0) ? 1'b1 : 1'b0;
      live = !sel_n && en;
      return {live && !mbx_sel && (dir == wr_lvl) && room_ok,
              live && !mbx_sel && (dir != wr_lvl) && data_ok,
              live && mbx_sel && (dir == wr_lvl),
              live && mbx_sel && (dir != wr_lvl)};
   endfunction

   function automatic logic [BUS_W-1:0] exp_oe(input int second);
      logic wr_lvl;
      wr_lvl = (second == 0) ? 1'b1 : 1'b0;
      return (!sel_n && dir != wr_lvl) ? {BUS_W{1'b1}} : '0;
   endfunction

   // Drive at the falling edge, check enables before the next rising edge, strobes after it.
   task automatic apply(input string req, input logic s, input logic d, input logic e,
                        input logic m, input logic r, input logic k);
      logic [3:0] ea, eb;
      @(negedge clk);
      sel_n = s; dir = d; en = e; mbx_sel = m; room_ok = r; data_ok = k;
      #0.5;
      check({req, " R1 oe A"}, 64'(a_oe), 64'(exp_oe(0)));
      check({req, " R7 oe B"}, 64'(b_oe), 64'(exp_oe(1)));
      ea = exp_stb(0);
      eb = exp_stb(1);
      @(posedge clk);
      #1;
      check({req, " strobes A"}, 64'({a_push, a_pop, a_mwr, a_mrd}), 64'(ea));
      check({req, " R7 strobes B"}, 64'({b_push, b_pop, b_mwr, b_mrd}), 64'(eb));
      check({req, " R8 onehot A"}, 64'($countones({a_push, a_pop, a_mwr, a_mrd}) <= 1), 64'd1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      sel_n = 1'b0; dir = 1'b1; en = 1'b1; room_ok = 1'b1; data_ok = 1'b1; mbx_sel = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset strobes A", 64'({a_push, a_pop, a_mwr, a_mrd}), 64'd0);
      check("R9 reset strobes B", 64'({b_push, b_pop, b_mwr, b_mrd}), 64'd0);
      @(negedge clk);
      sel_n = 1'b1; en = 1'b0;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R9 idle after reset", 64'({a_push, a_pop, b_push, b_pop}), 64'd0);
   endtask

   task automatic t_write();
      apply("R2 write", 0, 1, 1, 0, 1, 0);
      check("R2 push A", 64'(a_push), 64'd1);
   endtask

   task automatic t_read();
      apply("R3 read", 0, 0, 1, 0, 0, 1);
      check("R3 pop A", 64'(a_pop), 64'd1);
      check("R7 push B on low dir", 64'(b_push), 64'd0);
   endtask

   task automatic t_enable_low();
      apply("R4 en low write", 0, 1, 0, 0, 1, 1);
      check("R4 no push", 64'(a_push), 64'd0);
      apply("R4 en low read", 0, 0, 0, 0, 1, 1);
      check("R4 no pop", 64'(a_pop), 64'd0);
   endtask

   task automatic t_mailbox();
      apply("R5 mbx write", 0, 1, 1, 1, 0, 0);
      check("R5 mbx_wr A", 64'(a_mwr), 64'd1);
      apply("R5 mbx read", 0, 0, 1, 1, 1, 1);
      check("R5 mbx_rd A no pop", 64'({a_pop, a_mrd}), 64'b01);
   endtask

   task automatic t_flags();
      apply("R6 full blocks", 0, 1, 1, 0, 0, 1);
      check("R6 push blocked", 64'(a_push), 64'd0);
      apply("R6 empty blocks", 0, 0, 1, 0, 1, 0);
      check("R6 pop blocked", 64'(a_pop), 64'd0);
   endtask

   task automatic t_burst();
      for (int i = 0; i < 3; i++) begin
         apply("R10 burst", 0, 1, 1, 0, 1, 0);
         check("R10 burst push", 64'(a_push), 64'd1);
      end
      apply("R10 burst end", 1, 1, 1, 0, 1, 0);
      check("R10 push drops", 64'(a_push), 64'd0);
   endtask

   task automatic t_sweep();
      for (int v = 0; v < 64; v++) begin
         apply("R1 R2 R3 R5 R6 sweep", v[5], v[4], v[3], v[2], v[1], v[0]);
      end
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write();
      t_read();
      t_enable_low();
      t_mailbox();
      t_flags();
      t_burst();
      t_sweep();
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule